// File: doc/BRIEF.md
# Register Rename Unit with Stand-Alone Rename Buffers

This block renames the registers of one register class for an out-of-order core. It keeps a mapping table from architectural registers to rename-buffer indices, a pool of free rename buffers, a file of rename buffers that hold speculative results, and the architectural register file itself. The rename buffers are separate from the architectural registers, so retiring a result copies it into the architectural file.

At issue the unit resolves both source operands against the table. For each source it reports whether the source is renamed. For a renamed source it gives the buffer index and either the buffer's value or a pending flag. For a source that is not renamed it gives the architectural register number and that register's value. In the same cycle it gives the destination the lowest-numbered free buffer and points the table at that buffer.

Execution units write finished results into buffers by index. At completion the unit copies the buffer into the architectural register that owns it and returns the buffer to the pool. It clears the table entry only when that entry still names the completing buffer. A flush input discards every mapping and frees every buffer. The architectural values are kept.

Top module: `rnm_rename_unit`

## Requirements
- R1: After reset no architectural register is mapped, all rename buffers are free and every architectural register reads as zero.
- R2: When `iss_valid_i` is high and a buffer is free, the lowest-numbered free buffer is allocated and its index appears on `iss_tag_o` in that cycle. The destination then maps to that buffer. `iss_ready_o` is low exactly when no buffer is free, and an issue in that state changes nothing.
- R3: A source lookup drives the renamed flag high and the buffer index (zero-extended) on the index output when a valid mapping exists. Otherwise the flag is low and the index output carries the architectural register number.
- R4: A renamed source whose buffer holds data returns the buffer value with pending low. A renamed source whose buffer has no data returns pending high and value zero. A source that is not renamed returns the architectural register value with pending low.
- R5: A result write sets the buffer's data and marks it present from the next cycle. Allocating a buffer marks it not present.
- R6: A completion writes the buffer value into the architectural register recorded at allocation and returns the buffer to the free pool.
- R7: A completion clears the mapping of its architectural register only if the table still names the completing buffer. A newer mapping of the same register survives.
- R8: Source lookups see the table as it was before the current instruction's own destination is remapped in the same cycle.
- R9: A flush clears all mappings, frees all buffers, suppresses any issue or completion in the same cycle and leaves the architectural registers unchanged.
- R10: When an issue remaps a register in the same cycle that the older mapping of that register completes, the new mapping is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard all mappings and free all buffers |
| iss_valid_i | input | 1 | Instruction presented for rename |
| iss_dst_i | input | AW | Destination architectural register |
| iss_src0_i | input | AW | First source architectural register |
| iss_src1_i | input | AW | Second source architectural register |
| iss_ready_o | output | 1 | A free buffer is available |
| iss_tag_o | output | TW | Buffer allocated to the destination |
| src0_ren_o | output | 1 | First source is renamed |
| src0_idx_o | output | IW | Buffer index or architectural number of first source |
| src0_pend_o | output | 1 | First source value not yet produced |
| src0_val_o | output | DW | First source value |
| src1_ren_o | output | 1 | Second source is renamed |
| src1_idx_o | output | IW | Buffer index or architectural number of second source |
| src1_pend_o | output | 1 | Second source value not yet produced |
| src1_val_o | output | DW | Second source value |
| res_valid_i | input | 1 | Finished result write |
| res_tag_i | input | TW | Buffer receiving the result |
| res_data_i | input | DW | Result value |
| cmp_valid_i | input | 1 | Oldest instruction completes |
| cmp_tag_i | input | TW | Buffer of the completing instruction |

## Verification
The bench cycles every architectural register through issue, result write, completion and readback. It looks up the same register before, during and after each step, which separates the pending, the buffered and the retired value paths. Two sources then read the same register while the pool is made to reuse buffers. This separates the same-cycle lookup from a lookup taken after the remap. A stale completion, a completion that coincides with a remap, issue into a full pool and a flush that coincides with issue and completion each check that the newest mapping wins. A full lookup sweep after reset and after the flush confirms the clean table and that the architectural values survive the flush.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rnm_free_pool.sv
module rnm_free_pool #(
  parameter int NREN = 4,
  parameter int TW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            take_i,
  input  logic            give_i,
  input  logic [TW-1:0]   give_idx_i,
  output logic            ok_o,
  output logic [TW-1:0]   idx_o,
  output logic [NREN-1:0] free_o
);
  logic [NREN-1:0] free_q, free_d;

  always_comb begin
    idx_o = '0;
    for (int i = NREN - 1; i >= 0; i--) begin
      if (free_q[i]) idx_o = TW'(i);
    end
    ok_o = |free_q;
  end

  always_comb begin
    free_d = free_q;
    if (take_i) free_d[idx_o] = 1'b0;
    if (give_i) free_d[give_idx_i] = 1'b1;
    if (flush_i) free_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

  assign free_o = free_q;

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !flush_i |=> !free_q[$past(idx_o)]);  // R2
  AST_GIVE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    give_i && !flush_i |=> free_q[$past(give_idx_i)]);  // R6
  AST_FLUSH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> &free_q);  // R9
endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
  parameter int NARCH = 8,
  parameter int AW    = 3,
  parameter int TW    = 2,
  parameter int NRD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush_i,
  input  logic                      upd_en_i,
  input  logic [AW-1:0]             upd_arch_i,
  input  logic [TW-1:0]             upd_tag_i,
  input  logic                      clr_en_i,
  input  logic [AW-1:0]             clr_arch_i,
  input  logic [TW-1:0]             clr_tag_i,
  input  logic [NRD-1:0][AW-1:0]    rd_arch_i,
  output logic [NRD-1:0]            rd_v_o,
  output logic [NRD-1:0][TW-1:0]    rd_tag_o,
  output logic [NARCH-1:0]          map_v_o,
  output logic [NARCH-1:0][TW-1:0]  map_tag_o
);
  logic [NARCH-1:0]         v_q, v_d;
  logic [NARCH-1:0][TW-1:0] t_q, t_d;

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_v_o[k]   = v_q[rd_arch_i[k]];
    assign rd_tag_o[k] = t_q[rd_arch_i[k]];
  end

  always_comb begin
    v_d = v_q;
    t_d = t_q;
    if (clr_en_i && v_q[clr_arch_i] && (t_q[clr_arch_i] == clr_tag_i))
      v_d[clr_arch_i] = 1'b0;
    if (upd_en_i) begin
      v_d[upd_arch_i] = 1'b1;
      t_d[upd_arch_i] = upd_tag_i;
    end
    if (flush_i) v_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      t_q <= '0;
    end else begin
      v_q <= v_d;
      t_q <= t_d;
    end
  end

  assign map_v_o   = v_q;
  assign map_tag_o = t_q;

  AST_STALE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i && !flush_i && v_q[clr_arch_i] && (t_q[clr_arch_i] != clr_tag_i)
    |=> v_q[$past(clr_arch_i)]);  // R7
  AST_REMAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i && !flush_i |=> v_q[$past(upd_arch_i)] &&
    (t_q[$past(upd_arch_i)] == $past(upd_tag_i)));  // R10
  AST_FLUSH_UNMAPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (v_q == '0));  // R9
endmodule

// File: rtl/rnm_buf_file.sv
module rnm_buf_file #(
  parameter int NREN = 4,
  parameter int TW   = 2,
  parameter int AW   = 3,
  parameter int DW   = 16,
  parameter int NRD  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_en_i,
  input  logic [TW-1:0]           alloc_idx_i,
  input  logic [AW-1:0]           alloc_owner_i,
  input  logic                    wr_en_i,
  input  logic [TW-1:0]           wr_idx_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [NRD-1:0][TW-1:0]  rd_idx_i,
  output logic [NRD-1:0]          rd_vld_o,
  output logic [NRD-1:0][DW-1:0]  rd_data_o,
  input  logic [TW-1:0]           cmp_idx_i,
  output logic [AW-1:0]           cmp_owner_o,
  output logic [DW-1:0]           cmp_data_o,
  output logic                    cmp_vld_o
);
  logic [NREN-1:0]         vld_q, vld_d;
  logic [NREN-1:0][DW-1:0] dat_q, dat_d;
  logic [NREN-1:0][AW-1:0] own_q, own_d;

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_vld_o[k]  = vld_q[rd_idx_i[k]];
    assign rd_data_o[k] = dat_q[rd_idx_i[k]];
  end

  assign cmp_owner_o = own_q[cmp_idx_i];
  assign cmp_data_o  = dat_q[cmp_idx_i];
  assign cmp_vld_o   = vld_q[cmp_idx_i];

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    own_d = own_q;
    if (wr_en_i) begin
      vld_d[wr_idx_i] = 1'b1;
      dat_d[wr_idx_i] = wr_data_i;
    end
    if (alloc_en_i) begin
      vld_d[alloc_idx_i] = 1'b0;
      own_d[alloc_idx_i] = alloc_owner_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
      own_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      own_q <= own_d;
    end
  end

  AST_RESULT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !(alloc_en_i && (alloc_idx_i == wr_idx_i))
    |=> vld_q[$past(wr_idx_i)]);  // R5
  AST_ALLOC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en_i |=> !vld_q[$past(alloc_idx_i)]);  // R5
endmodule

// File: rtl/rnm_arch_file.sv
module rnm_arch_file #(
  parameter int NARCH = 8,
  parameter int AW    = 3,
  parameter int DW    = 16,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_arch_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [NRD-1:0][AW-1:0]  rd_arch_i,
  output logic [NRD-1:0][DW-1:0]  rd_data_o
);
  logic [NARCH-1:0][DW-1:0] reg_q, reg_d;

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_data_o[k] = reg_q[rd_arch_i[k]];
  end

  always_comb begin
    reg_d = reg_q;
    if (wr_en_i) reg_d[wr_arch_i] = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  AST_ARCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(reg_q));  // R6
  AST_ARCH_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> reg_q[$past(wr_arch_i)] == $past(wr_data_i));  // R6
endmodule

// File: rtl/rnm_rename_unit.sv
module rnm_rename_unit #(
  parameter int NARCH = 8,
  parameter int NREN  = 4,
  parameter int DW    = 16,
  localparam int AW   = $clog2(NARCH),
  localparam int TW   = $clog2(NREN),
  localparam int IW   = rnm_pkg::imax(AW, TW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          iss_valid_i,
  input  logic [AW-1:0] iss_dst_i,
  input  logic [AW-1:0] iss_src0_i,
  input  logic [AW-1:0] iss_src1_i,
  output logic          iss_ready_o,
  output logic [TW-1:0] iss_tag_o,
  output logic          src0_ren_o,
  output logic [IW-1:0] src0_idx_o,
  output logic          src0_pend_o,
  output logic [DW-1:0] src0_val_o,
  output logic          src1_ren_o,
  output logic [IW-1:0] src1_idx_o,
  output logic          src1_pend_o,
  output logic [DW-1:0] src1_val_o,
  input  logic          res_valid_i,
  input  logic [TW-1:0] res_tag_i,
  input  logic [DW-1:0] res_data_i,
  input  logic          cmp_valid_i,
  input  logic [TW-1:0] cmp_tag_i
);
  localparam int NRD = 2;

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic                      alloc_ok, iss_fire, cmp_fire;
  logic [TW-1:0]             alloc_idx;
  logic [NREN-1:0]           free_vec;
  logic [NRD-1:0][AW-1:0]    src_arch;
  logic [NRD-1:0]            map_hit;
  logic [NRD-1:0][TW-1:0]    map_tag;
  logic [NARCH-1:0]          all_v;
  logic [NARCH-1:0][TW-1:0]  all_tag;
  logic [NRD-1:0]            buf_vld;
  logic [NRD-1:0][DW-1:0]    buf_dat, arc_dat;
  logic [AW-1:0]             cmp_owner;
  logic [DW-1:0]             cmp_data;
  logic                      cmp_vld;
  logic [NRD-1:0]            s_ren, s_pend;
  logic [NRD-1:0][IW-1:0]    s_idx;
  logic [NRD-1:0][DW-1:0]    s_val;

  assign iss_fire    = iss_valid_i & alloc_ok & ~flush_i;
  assign cmp_fire    = cmp_valid_i & ~flush_i;
  assign iss_ready_o = alloc_ok;
  assign iss_tag_o   = alloc_idx;
  assign src_arch[0] = iss_src0_i;
  assign src_arch[1] = iss_src1_i;

  rnm_free_pool #(.NREN(NREN), .TW(TW)) u_pool (
    .clk(clk), .rst_n(rst_sync_n), .flush_i(flush_i),
    .take_i(iss_fire), .give_i(cmp_fire), .give_idx_i(cmp_tag_i),
    .ok_o(alloc_ok), .idx_o(alloc_idx), .free_o(free_vec)
  );

  rnm_map_table #(.NARCH(NARCH), .AW(AW), .TW(TW), .NRD(NRD)) u_map (
    .clk(clk), .rst_n(rst_sync_n), .flush_i(flush_i),
    .upd_en_i(iss_fire), .upd_arch_i(iss_dst_i), .upd_tag_i(alloc_idx),
    .clr_en_i(cmp_fire), .clr_arch_i(cmp_owner), .clr_tag_i(cmp_tag_i),
    .rd_arch_i(src_arch), .rd_v_o(map_hit), .rd_tag_o(map_tag),
    .map_v_o(all_v), .map_tag_o(all_tag)
  );

  rnm_buf_file #(.NREN(NREN), .TW(TW), .AW(AW), .DW(DW), .NRD(NRD)) u_buf (
    .clk(clk), .rst_n(rst_sync_n),
    .alloc_en_i(iss_fire), .alloc_idx_i(alloc_idx), .alloc_owner_i(iss_dst_i),
    .wr_en_i(res_valid_i), .wr_idx_i(res_tag_i), .wr_data_i(res_data_i),
    .rd_idx_i(map_tag), .rd_vld_o(buf_vld), .rd_data_o(buf_dat),
    .cmp_idx_i(cmp_tag_i), .cmp_owner_o(cmp_owner), .cmp_data_o(cmp_data),
    .cmp_vld_o(cmp_vld)
  );

  rnm_arch_file #(.NARCH(NARCH), .AW(AW), .DW(DW), .NRD(NRD)) u_arch (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en_i(cmp_fire), .wr_arch_i(cmp_owner), .wr_data_i(cmp_data),
    .rd_arch_i(src_arch), .rd_data_o(arc_dat)
  );

  for (genvar k = 0; k < NRD; k++) begin : g_src
    always_comb begin
      s_ren[k]  = map_hit[k];
      s_pend[k] = map_hit[k] & ~buf_vld[k];
      if (map_hit[k]) begin
        s_idx[k] = IW'(map_tag[k]);
        s_val[k] = buf_vld[k] ? buf_dat[k] : '0;
      end else begin
        s_idx[k] = IW'(src_arch[k]);
        s_val[k] = arc_dat[k];
      end
    end
  end

  assign src0_ren_o  = s_ren[0];
  assign src0_idx_o  = s_idx[0];
  assign src0_pend_o = s_pend[0];
  assign src0_val_o  = s_val[0];
  assign src1_ren_o  = s_ren[1];
  assign src1_idx_o  = s_idx[1];
  assign src1_pend_o = s_pend[1];
  assign src1_val_o  = s_val[1];

  AST_CMP_FINISHED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_fire |-> cmp_vld);  // R6

  for (genvar a = 0; a < NARCH; a++) begin : g_chk
    AST_MAP_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
      all_v[a] |-> !free_vec[all_tag[a]]);  // R2
  end
endmodule

// File: tb/rnm_rename_unit_tb.sv
module rnm_rename_unit_tb;
  localparam int NA = 8;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n, flush_i, iss_valid_i, res_valid_i, cmp_valid_i;
  logic [2:0]  iss_dst_i, iss_src0_i, iss_src1_i;
  logic [1:0]  res_tag_i, cmp_tag_i, iss_tag_o;
  logic [15:0] res_data_i, src0_val_o, src1_val_o;
  logic        iss_ready_o, src0_ren_o, src0_pend_o, src1_ren_o, src1_pend_o;
  logic [2:0]  src0_idx_o, src1_idx_o;

  always #4 clk = ~clk;

  rnm_rename_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .iss_valid_i(iss_valid_i), .iss_dst_i(iss_dst_i),
    .iss_src0_i(iss_src0_i), .iss_src1_i(iss_src1_i),
    .iss_ready_o(iss_ready_o), .iss_tag_o(iss_tag_o),
    .src0_ren_o(src0_ren_o), .src0_idx_o(src0_idx_o),
    .src0_pend_o(src0_pend_o), .src0_val_o(src0_val_o),
    .src1_ren_o(src1_ren_o), .src1_idx_o(src1_idx_o),
    .src1_pend_o(src1_pend_o), .src1_val_o(src1_val_o),
    .res_valid_i(res_valid_i), .res_tag_i(res_tag_i), .res_data_i(res_data_i),
    .cmp_valid_i(cmp_valid_i), .cmp_tag_i(cmp_tag_i)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  bit m_mv[NA];
  int m_mi[NA];
  int m_arch[NA];
  bit m_free[NR];
  bit m_bv[NR];
  int m_bd[NR];
  int m_own[NR];

  function automatic int lowest_free();
    for (int i = 0; i < NR; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_src(string rq, string nm, int s, int ren, int idx, int pend, int val);
    int eren, eidx, epend, eval;
    eren  = m_mv[s];
    eidx  = eren ? m_mi[s] : s;
    epend = eren && !m_bv[m_mi[s]];
    eval  = !eren ? m_arch[s] : (m_bv[m_mi[s]] ? m_bd[m_mi[s]] : 0);
    chk(rq, {nm, " renamed"}, ren, eren);
    chk(rq, {nm, " index"}, idx, eidx);
    chk(rq, {nm, " pending"}, pend, epend);
    chk(rq, {nm, " value"}, val, eval);
  endtask

  task automatic cyc(string rq, bit iv, int id, int s0, int s1,
                     bit wv, int wt, int wd, bit cv, int ct, bit fl);
    int lf, own;
    flush_i = fl; iss_valid_i = iv; iss_dst_i = 3'(id);
    iss_src0_i = 3'(s0); iss_src1_i = 3'(s1);
    res_valid_i = wv; res_tag_i = 2'(wt); res_data_i = 16'(wd);
    cmp_valid_i = cv; cmp_tag_i = 2'(ct);
    #1;
    lf = lowest_free();
    chk(rq, "ready", int'(iss_ready_o), int'(lf >= 0));
    if (lf >= 0) chk(rq, "alloc tag", int'(iss_tag_o), lf);
    chk_src(rq, "src0", s0, int'(src0_ren_o), int'(src0_idx_o), int'(src0_pend_o), int'(src0_val_o));
    chk_src(rq, "src1", s1, int'(src1_ren_o), int'(src1_idx_o), int'(src1_pend_o), int'(src1_val_o));
    @(posedge clk);
    if (wv) begin m_bd[wt] = wd & 16'hffff; m_bv[wt] = 1; end
    if (fl) begin
      for (int a = 0; a < NA; a++) m_mv[a] = 0;
      for (int b = 0; b < NR; b++) m_free[b] = 1;
    end else begin
      if (cv) begin
        own = m_own[ct];
        m_arch[own] = m_bd[ct];
        m_free[ct] = 1;
        if (m_mv[own] && m_mi[own] == ct) m_mv[own] = 0;
      end
      if (iv && lf >= 0) begin
        m_free[lf] = 0; m_bv[lf] = 0; m_own[lf] = id;
        m_mv[id] = 1; m_mi[id] = lf;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(string rq, int s0, int s1);
    cyc(rq, 0, 0, s0, s1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int t, ta, tb, tc, d;
    rst_n = 0; flush_i = 0; iss_valid_i = 0; res_valid_i = 0; cmp_valid_i = 0;
    iss_dst_i = 0; iss_src0_i = 0; iss_src1_i = 0;
    res_tag_i = 0; res_data_i = 0; cmp_tag_i = 0;
    for (int a = 0; a < NA; a++) begin m_mv[a] = 0; m_mi[a] = 0; m_arch[a] = 0; end
    for (int b = 0; b < NR; b++) begin m_free[b] = 1; m_bv[b] = 0; m_bd[b] = 0; m_own[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: clean table after reset, all pairs of sources
    for (int a = 0; a < NA; a++) idle("R1", a, NA - 1 - a);

    // Every register: issue, result, completion, readback
    for (int i = 0; i < NA; i++) begin
      t = lowest_free();
      d = (i * 16'h0111 + 16'h0a05) & 16'hffff;
      cyc("R8", 1, i, i, (i + 1) % NA, 0, 0, 0, 0, 0, 0);
      cyc("R3", 0, 0, i, i, 1, t, d, 0, 0, 0);
      cyc("R5", 0, 0, i, (i + 2) % NA, 0, 0, 0, 1, t, 0);
      idle("R6", i, (i + 3) % NA);
    end

    // Remap of one register and stale completion
    ta = lowest_free();
    cyc("R2", 1, 2, 2, 2, 0, 0, 0, 0, 0, 0);
    cyc("R5", 0, 0, 2, 2, 1, ta, 16'h5a5a, 0, 0, 0);
    tb = lowest_free();
    cyc("R3", 1, 2, 2, 5, 0, 0, 0, 0, 0, 0);
    cyc("R4", 0, 0, 2, 2, 1, tb, 16'hc3c3, 0, 0, 0);
    cyc("R7", 0, 0, 2, 2, 0, 0, 0, 1, ta, 0);
    idle("R7", 2, 3);
    tc = lowest_free();
    cyc("R10", 1, 2, 2, 2, 0, 0, 0, 1, tb, 0);
    idle("R10", 2, 2);

    // Fill the pool, then issue into a full pool
    for (int k = 0; k < NR; k++)
      if (lowest_free() >= 0) cyc("R2", 1, 4 + (k % 3), 4, 6, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 7, 7, 4, 0, 0, 0, 0, 0, 0);
    idle("R2", 7, 5);
    idle("R4", 6, 2);

    // Flush coinciding with issue and completion
    cyc("R9", 1, 1, 1, 3, 1, tc, 16'h7777, 1, tc, 1);
    for (int a = 0; a < NA; a++) idle("R9", a, (a + 5) % NA);
    cyc("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R9", 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule